// File: doc/BRIEF.md
# Batch-Norm Gradient Sum Reducer

This block performs the reduction step of the batch-normalization backward pass for one channel. A mean and an inverse standard deviation, both computed earlier by the forward pass, are latched first. The block then takes a stream of paired samples over a valid/ready handshake. Each beat carries one forward-output value, one incoming-gradient value and a last flag for each of the two streams.

For each beat the block forms the normalized input on the fly as (forward − mean) × inverse-std. It folds that value into three running sums: the sum of the gradient, the sum of gradient × normalized input, and the sum of the normalized input. When a beat carries a last flag, the block presents the three raw sums on its result port together with a one-cycle done pulse. It applies no division and no scale factor. All values are signed fixed point: inputs are Q8.8, the accumulators are 40 bits wide, and each output saturates to 32 bits. Each reduction starts from zero, so no result carries over to the next one.

The controller has three states. ST_IDLE waits for the first beat of a reduction and is the only state in which new operands may be loaded. ST_ACCUM is the middle of a reduction. ST_REPORT is a single cycle in which the results are published. The transitions are:
- ST_IDLE→ST_ACCUM on an accepted beat without a last flag.
- ST_IDLE→ST_REPORT on an accepted beat with a last flag, which is a one-sample reduction.
- ST_ACCUM→ST_REPORT on an accepted beat with a last flag.
- ST_REPORT→ST_IDLE unconditionally.

Top module: `bn_grad_reducer`

## Requirements
- R1: A high `load_stb` in ST_IDLE, in a cycle with no accepted beat, latches `mean_in` and `istd_in`. At any other time `load_stb` has no effect, and the latched operands stay unchanged until the reduction has been reported.
- R2: A beat is accepted when `s_valid` and `s_ready` are both high. `s_ready` is high in ST_IDLE and ST_ACCUM and low in ST_REPORT.
- R3: For each beat, the normalized input is xn = floor((fwd − mean) × istd / 256), with all operands read as signed Q8.8 two's complement.
- R4: `res_shift` is the sum of `s_grad` over all accepted beats of the reduction.
- R5: `res_scale` is the sum over all beats of floor(grad × xn / 256).
- R6: `res_norm` is the sum of xn over all beats.
- R7: The first accepted beat of each reduction starts all three sums from zero. Each report overwrites the previous results and never adds to them.
- R8: A beat with either last flag set ends the reduction. `res_done` rises for exactly one cycle, two clock edges after that beat is accepted. The results and `res_err` hold their values until the next report.
- R9: Each sum is held in 40 bits and saturates on output to the signed 32-bit range [−2^31, 2^31−1].
- R10: If the two last flags differ on any beat of a reduction, `res_err` is 1 with the report of that reduction. A reduction without such a beat reports `res_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_stb | input | 1 | Operand load strobe |
| mean_in | input | 16 | Mean, signed Q8.8 |
| istd_in | input | 16 | Inverse standard deviation, signed Q8.8 |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Sample beat ready |
| s_fwd | input | 16 | Forward-output sample, signed Q8.8 |
| s_grad | input | 16 | Incoming gradient sample, signed Q8.8 |
| s_fwd_last | input | 1 | Last flag of the forward stream |
| s_grad_last | input | 1 | Last flag of the gradient stream |
| res_done | output | 1 | One-cycle report pulse |
| res_err | output | 1 | Last flags disagreed; results are invalid |
| res_shift | output | 32 | Sum of gradients |
| res_scale | output | 32 | Sum of gradient × normalized input |
| res_norm | output | 32 | Sum of normalized input |

## Verification
Two situations are hard to reach from the ports. The first is output saturation, which needs sums beyond 32 bits. Directed reductions reach it by pairing extreme operand and sample values, so that each gradient-product term lies near 2^30 and a few beats overflow. The second is a load strobe that arrives in the middle of a reduction, and the bench raises one on a chosen beat. Reductions with mismatched last flags are followed at once by clean ones, which checks that the error flag and all three sums start fresh. The bench also exercises one-sample reductions and random stall gaps on the valid signal.

// File: rtl/bngr_pkg.sv
package bngr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCUM  = 2'd1,
        ST_REPORT = 2'd2
    } bngr_state_e;

    localparam int NUM_SUMS  = 3;
    localparam int SUM_SHIFT = 0;   // sum of gradient
    localparam int SUM_SCALE = 1;   // sum of gradient x normalized input
    localparam int SUM_NORM  = 2;   // sum of normalized input

endpackage

// File: rtl/bngr_norm.sv
module bngr_norm #(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int NW   = 2*DW + 1 - FRAC
) (
    input  logic signed [DW-1:0] fwd,
    input  logic signed [DW-1:0] mean,
    input  logic signed [DW-1:0] istd,
    output logic signed [NW-1:0] xn
);
    localparam int DFW = DW + 1;
    localparam int PW  = 2*DW + 1;

    logic signed [DFW-1:0] diff;
    logic signed [PW-1:0]  prod;

    always_comb begin
        diff = DFW'(fwd) - DFW'(mean);
        prod = PW'(diff) * PW'(istd);
        xn   = NW'(prod >>> FRAC);   // R3: floor shift back to Q8.8
    end

endmodule

// File: rtl/bngr_accum.sv
module bngr_accum
    import bngr_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int NW   = 2*DW + 1 - FRAC,
    parameter int AW   = 40
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             en,
    input  logic                             first,
    input  logic signed [DW-1:0]             grad,
    input  logic signed [NW-1:0]             xn,
    output logic [NUM_SUMS-1:0][AW-1:0]      acc
);
    localparam int MW = DW + NW;

    logic signed [MW-1:0]          gprod;
    logic [NUM_SUMS-1:0][AW-1:0]   term;
    logic [NUM_SUMS-1:0][AW-1:0]   acc_q;

    always_comb begin
        gprod            = MW'(grad) * MW'(xn);
        term[SUM_SHIFT]  = AW'(grad);
        term[SUM_SCALE]  = AW'(gprod >>> FRAC);
        term[SUM_NORM]   = AW'(xn);
    end

    for (genvar i = 0; i < NUM_SUMS; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[i] <= '0;
            end else if (en) begin
                acc_q[i] <= (first ? '0 : acc_q[i]) + term[i];
            end
        end
    end

    assign acc = acc_q;

    AST_FIRST_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && first) |=> ($signed(acc_q[SUM_SHIFT]) == AW'($past(grad)))); // R7

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q)); // R8

endmodule

// File: rtl/bn_grad_reducer.sv
module bn_grad_reducer
    import bngr_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int AW   = 40,
    parameter int OW   = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_stb,
    input  logic [DW-1:0] mean_in,
    input  logic [DW-1:0] istd_in,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic [DW-1:0] s_fwd,
    input  logic [DW-1:0] s_grad,
    input  logic          s_fwd_last,
    input  logic          s_grad_last,
    output logic          res_done,
    output logic          res_err,
    output logic [OW-1:0] res_shift,
    output logic [OW-1:0] res_scale,
    output logic [OW-1:0] res_norm
);
    localparam int NW = 2*DW + 1 - FRAC;
    localparam logic signed [AW-1:0] SAT_HI = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [AW-1:0] SAT_LO = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    bngr_state_e state_q, state_d;

    logic signed [DW-1:0]           mean_q, istd_q;
    logic signed [NW-1:0]           xn;
    logic [NUM_SUMS-1:0][AW-1:0]    acc;
    logic [NUM_SUMS-1:0][OW-1:0]    sat_w;
    logic [NUM_SUMS-1:0][OW-1:0]    res_q;
    logic                           err_q;
    logic                           beat, any_last, mism, first;

    assign beat     = s_valid && s_ready;
    assign any_last = s_fwd_last || s_grad_last;
    assign mism     = s_fwd_last ^ s_grad_last;
    assign first    = (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (beat) state_d = any_last ? ST_REPORT : ST_ACCUM;
            ST_ACCUM:  if (beat && any_last) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        s_ready = (state_q != ST_REPORT);
    end

    // operand latch: only between reductions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mean_q <= '0;
            istd_q <= '0;
        end else if (load_stb && state_q == ST_IDLE && !beat) begin
            mean_q <= $signed(mean_in);
            istd_q <= $signed(istd_in);
        end
    end

    // last-flag disagreement, restarted on the first beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    err_q <= 1'b0;
        else if (beat) err_q <= (first ? 1'b0 : err_q) | mism;
    end

    bngr_norm #(.DW(DW), .FRAC(FRAC), .NW(NW)) u_norm (
        .fwd  ($signed(s_fwd)),
        .mean (mean_q),
        .istd (istd_q),
        .xn   (xn)
    );

    bngr_accum #(.DW(DW), .FRAC(FRAC), .NW(NW), .AW(AW)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (beat),
        .first (first),
        .grad  ($signed(s_grad)),
        .xn    (xn),
        .acc   (acc)
    );

    for (genvar i = 0; i < NUM_SUMS; i++) begin : g_sat
        always_comb begin
            if ($signed(acc[i]) > SAT_HI)      sat_w[i] = {1'b0, {(OW-1){1'b1}}};
            else if ($signed(acc[i]) < SAT_LO) sat_w[i] = {1'b1, {(OW-1){1'b0}}};
            else                               sat_w[i] = OW'(acc[i]);
        end
    end

    // result register, published in ST_REPORT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_done <= 1'b0;
            res_err  <= 1'b0;
            res_q    <= '0;
        end else if (state_q == ST_REPORT) begin
            res_done <= 1'b1;
            res_err  <= err_q;
            res_q    <= sat_w;
        end else begin
            res_done <= 1'b0;
        end
    end

    assign res_shift = res_q[SUM_SHIFT];
    assign res_scale = res_q[SUM_SCALE];
    assign res_norm  = res_q[SUM_NORM];

    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(mean_q) && $stable(istd_q))); // R1

    AST_NO_READY_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPORT) |-> !s_ready); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> !res_done); // R8

    AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && any_last) |=> ##1 res_done); // R8

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPORT && $signed(acc[SUM_SCALE]) > SAT_HI)
            |=> (res_scale == {1'b0, {(OW-1){1'b1}}})); // R9

    AST_MISMATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && mism) |=> ##1 (res_done && res_err)); // R10

endmodule

// File: tb/bn_grad_reducer_tb.sv
module bn_grad_reducer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_stb = 1'b0;
    logic [15:0] mean_in = '0, istd_in = '0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [15:0] s_fwd = '0, s_grad = '0;
    logic        s_fwd_last = 1'b0, s_grad_last = 1'b0;
    logic        res_done, res_err;
    logic [31:0] res_shift, res_scale, res_norm;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int fa [64];
    int ga [64];
    int exp_mean = 0, exp_istd = 0;

    always #10 clk = ~clk;   // 50 MHz

    bn_grad_reducer u_dut (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb),
        .mean_in(mean_in), .istd_in(istd_in),
        .s_valid(s_valid), .s_ready(s_ready),
        .s_fwd(s_fwd), .s_grad(s_grad),
        .s_fwd_last(s_fwd_last), .s_grad_last(s_grad_last),
        .res_done(res_done), .res_err(res_err),
        .res_shift(res_shift), .res_scale(res_scale), .res_norm(res_norm)
    );

    function automatic longint xn_ref(int f, int m, int s);
        longint d = longint'(f) - longint'(m);
        return (d * longint'(s)) >>> 8;
    endfunction

    function automatic longint sat_ref(longint v);
        if (v > 64'sd2147483647)  return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load_ops(int m, int s);
        @(negedge clk);
        mean_in = 16'(m); istd_in = 16'(s); load_stb = 1'b1;
        exp_mean = m; exp_istd = s;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    // bad_at >= 0: forward last flag alone on that beat (ends the reduction)
    task automatic run_red(int n, int bad_at, bit poke_load);
        int last_i;
        longint e_shift, e_scale, e_norm, x;
        logic [31:0] h_shift, h_scale, h_norm;
        logic h_err;
        last_i = (bad_at >= 0) ? bad_at : n - 1;
        for (int i = 0; i <= last_i; i++) begin
            @(negedge clk);
            while (($urandom % 4) == 0) begin
                s_valid = 1'b0; load_stb = 1'b0;
                @(negedge clk);
            end
            s_valid = 1'b1;
            s_fwd = 16'(fa[i]); s_grad = 16'(ga[i]);
            s_fwd_last  = (i == last_i);
            s_grad_last = (i == last_i) && (bad_at < 0);
            load_stb = poke_load && (i == 1);
            if (load_stb) begin
                mean_in = 16'(exp_mean + 1234); istd_in = 16'(exp_istd + 77);
            end
            if (!s_ready) begin
                checks++; errors++;
                $display("FAIL R2: actual ready 0 expected 1 while accumulating");
            end
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0; load_stb = 1'b0; s_fwd_last = 1'b0; s_grad_last = 1'b0;
        check("R2 ready low in report", longint'(s_ready), 0);
        check("R8 done not yet", longint'(res_done), 0);
        e_shift = 0; e_scale = 0; e_norm = 0;
        for (int i = 0; i <= last_i; i++) begin
            x = xn_ref(fa[i], exp_mean, exp_istd);   // R3
            e_shift += ga[i];
            e_scale += (longint'(ga[i]) * x) >>> 8;
            e_norm  += x;
        end
        @(negedge clk);
        check("R8 done pulse", longint'(res_done), 1);
        check("R10 error flag", longint'(res_err), (bad_at >= 0) ? 1 : 0);
        if (bad_at < 0) begin
            check("R4 shift sum (R7 R9)", longint'($signed(res_shift)), sat_ref(e_shift));
            check("R5 scale sum (R3 R9)", longint'($signed(res_scale)), sat_ref(e_scale));
            check("R6 norm sum (R3 R9)",  longint'($signed(res_norm)),  sat_ref(e_norm));
        end
        h_shift = res_shift; h_scale = res_scale; h_norm = res_norm; h_err = res_err;
        @(negedge clk);
        check("R8 done single cycle", longint'(res_done), 0);
        check("R8 results held", longint'({h_shift, h_scale} ^ {res_shift, res_scale})
              + longint'(h_norm ^ res_norm) + longint'(h_err ^ res_err), 0);
    endtask

    task automatic fill_rand(int n, int span);
        for (int i = 0; i < n; i++) begin
            if (span == 0) begin
                fa[i] = $signed(16'($urandom)); ga[i] = $signed(16'($urandom));
            end else begin
                fa[i] = int'($urandom % (2*span)) - span;
                ga[i] = int'($urandom % (2*span)) - span;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R2 ready after reset", longint'(s_ready), 1);
        check("R8 done after reset", longint'(res_done), 0);
        check("R10 err after reset", longint'(res_err), 0);
        check("R4 result after reset", longint'(res_shift), 0);

        // directed: one-sample reduction, mean 1.0, istd 2.0
        load_ops(256, 512);
        fa[0] = 768; ga[0] = -128;
        run_red(1, -1, 1'b0);

        // directed: negative values, floor rounding of xn
        load_ops(-300, 77);
        fa[0] = -301; ga[0] = 3;  fa[1] = 5;  ga[1] = -7; fa[2] = -32768; ga[2] = 32767;
        run_red(3, -1, 1'b0);

        // directed: positive saturation
        load_ops(-32768, 32767);
        for (int i = 0; i < 4; i++) begin fa[i] = 32767; ga[i] = 32767; end
        run_red(4, -1, 1'b0);

        // directed: negative saturation
        for (int i = 0; i < 4; i++) begin fa[i] = 32767; ga[i] = -32768; end
        run_red(4, -1, 1'b0);

        // R1: load strobe mid-reduction must be ignored
        load_ops(100, 300);
        fill_rand(6, 2000);
        run_red(6, -1, 1'b1);
        fill_rand(5, 2000);
        run_red(5, -1, 1'b0);   // operands still the ones loaded before

        // R10: last flags disagree, then a clean reduction from zero (R7)
        fill_rand(8, 0);
        run_red(8, 3, 1'b0);
        fill_rand(4, 1000);
        run_red(4, -1, 1'b0);

        // constrained random
        for (int t = 0; t < 24; t++) begin
            int n;
            n = 1 + int'($urandom % 40);
            load_ops($signed(16'($urandom)), int'($urandom % 2048));
            fill_rand(n, (t % 2 == 0) ? 0 : 1500);
            if (t % 7 == 3) run_red(n, int'($urandom % n), 1'b0);
            else            run_red(n, -1, (n > 2) && (t % 5 == 0));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule